// File: doc/BRIEF.md
# Light-Load Mode Supervisor for a Synchronous Buck Channel

This block decides, for one switching channel, whether the power stage runs in constant-frequency PWM or in a light-load burst mode. In burst mode the stage behaves as a hysteretic window regulator. The analog comparators are modelled as digital flags.

Once per oscillator cycle the block receives a current sample. The sample is `smp_valid` plus `smp_heavy`, where `smp_heavy` means the sensed peak high-side current reached the light-load fraction of the limit. The three output-voltage comparator flags are level inputs and are looked at on every clock. The block leaves PWM only after an unbroken run of light samples. In burst mode it drives the high-side enable itself, between the nominal level and nominal +2%. It returns to PWM when the output sags 2% below nominal.

The sample input is a valid-only stream and has no ready. The block never applies back-pressure. It consumes exactly one sample on every clock that `smp_valid` is high, and a clock without `smp_valid` carries no sample. Force-PWM and soft-start are plain level controls.

Top module: `dual_mode_ctl`

## Requirements
- R1: A synchronous active-high `rst` gives `burst_mode`=0 (PWM), `hs_burst_on`=0 and `ilim_quarter`=0 on the clock after it is sampled. The light-sample run count is cleared, so a full fresh run is needed afterwards.
- R2: In PWM, with neither hold input high, the clock edge that takes the 16th consecutive valid sample with `smp_heavy`=0 sets `burst_mode`=1. After only 15 such samples the block stays in PWM.
- R3: A valid sample with `smp_heavy`=1 in PWM restarts the run, so 16 more light samples are needed.
- R4: Clocks with `smp_valid`=0 neither advance nor clear the run, whatever `smp_heavy` is.
- R5: While `force_pwm`=1 the block is in PWM from the next edge on and the run is cleared. A burst mode in progress ends at that edge.
- R6: While `ss_active`=1 the block behaves exactly as under R5.
- R7: In burst mode `hs_burst_on` rises on the edge after `vout_below_nom`=1 is seen. It stays high until `vout_above_hi`=1 is seen, then stays low until `vout_below_nom` is seen again.
- R8: `ilim_quarter`=1 (reduced, about one quarter, current limit) exactly while `burst_mode`=1.
- R9: In burst mode, `vout_below_lo`=1 returns the block to PWM on the next edge. At that same edge `hs_burst_on`=0 and `ilim_quarter`=0, which restores the full limit.
- R10: `hs_burst_on` is never high while `burst_mode`=0, and comparator flags have no effect on it in PWM.
- R11: When `vout_above_hi` and `vout_below_nom` are high together in burst mode, the switch is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | A per-oscillator-cycle current sample is present |
| smp_heavy | input | 1 | Sampled peak current at or above the light-load fraction |
| vout_below_nom | input | 1 | Output below nominal |
| vout_above_hi | input | 1 | Output above nominal +2% |
| vout_below_lo | input | 1 | Output below nominal -2% |
| force_pwm | input | 1 | Hold the channel in PWM |
| ss_active | input | 1 | Soft-start running, hold PWM |
| burst_mode | output | 1 | 1 = burst mode, 0 = PWM |
| hs_burst_on | output | 1 | High-side enable of the burst window regulator |
| ilim_quarter | output | 1 | Select the reduced current limit |

## Verification
A run counter that is off by one, or that is not cleared by a heavy sample or a hold, shows at `burst_mode`. The entry edge moves by exactly the error, so it appears within one sample of the expected 16th light sample. A stuck or mis-prioritised window register appears on `hs_burst_on` one clock after the comparator flag that should have moved it. A mode register that ignores the low threshold leaves `ilim_quarter` high one clock too long. Every output is compared against a reference model on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic {
    MODE_PWM   = 1'b0,
    MODE_BURST = 1'b1
  } dlm_mode_e;
endpackage

// File: rtl/dlm_light_cnt.sv
// Counts consecutive light-load samples; saturates at ENTRY_CYCLES.
module dlm_light_cnt #(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic smp_valid_i,
  input  logic smp_heavy_i,
  output logic run_done_o
);
  localparam int CNT_W = $clog2(ENTRY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(ENTRY_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_q <= '0;
    end else if (smp_valid_i) begin
      if (smp_heavy_i)        cnt_q <= '0;
      else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  // This sample completes the run of light cycles.
  assign run_done_o = !clr_i && smp_valid_i && !smp_heavy_i && (cnt_q >= LAST);

  p_heavy_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_i && smp_heavy_i) |=> (cnt_q == '0));
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == FULL && !clr_i && !(smp_valid_i && smp_heavy_i)) |=> (cnt_q == FULL));
  p_idle_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dlm_burst_win.sv
// Hysteretic window regulator driving the high-side enable in burst mode.
module dlm_burst_win (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic below_nom_i,
  input  logic above_hi_i,
  output logic hs_o
);
  logic hs_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)     hs_q <= 1'b0;
    else if (above_hi_i)  hs_q <= 1'b0;
    else if (below_nom_i) hs_q <= 1'b1;
  end

  assign hs_o = hs_q;

  p_turn_on_r7: assert property (@(posedge clk) disable iff (rst)
    (en_i && below_nom_i && !above_hi_i) |=> hs_o);
  p_upper_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (en_i && above_hi_i) |=> !hs_o);
  p_disabled_off_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !hs_o);
endmodule

// File: rtl/dlm_mode_fsm.sv
// Registered PWM / burst mode selection.
module dlm_mode_fsm
  import dlm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hold_i,
  input  logic      below_lo_i,
  input  logic      run_done_i,
  output dlm_mode_e mode_o,
  output logic      stay_burst_o
);
  dlm_mode_e mode_q, mode_d;

  assign stay_burst_o = (mode_q == MODE_BURST) && !hold_i && !below_lo_i;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_PWM:   if (!hold_i && run_done_i) mode_d = MODE_BURST;
      MODE_BURST: if (!stay_burst_o)         mode_d = MODE_PWM;
      default:                               mode_d = MODE_PWM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_PWM;
    else     mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_hold_pwm_r5: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> (mode_o == MODE_PWM));
  p_low_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_BURST && below_lo_i) |=> (mode_o == MODE_PWM));
  p_entry_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_PWM && !run_done_i) |=> (mode_o == MODE_PWM));
endmodule

// File: rtl/dual_mode_ctl.sv
module dual_mode_ctl
  import dlm_pkg::*;
#(
  parameter int ENTRY_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_valid,
  input  logic smp_heavy,
  input  logic vout_below_nom,
  input  logic vout_above_hi,
  input  logic vout_below_lo,
  input  logic force_pwm,
  input  logic ss_active,
  output logic burst_mode,
  output logic hs_burst_on,
  output logic ilim_quarter
);
  dlm_mode_e mode;
  logic      hold, run_done, stay_burst, cnt_clr;

  assign hold    = force_pwm || ss_active;
  assign cnt_clr = hold || (mode == MODE_BURST);

  dlm_light_cnt #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_cnt (
    .clk(clk), .rst(rst), .clr_i(cnt_clr),
    .smp_valid_i(smp_valid), .smp_heavy_i(smp_heavy),
    .run_done_o(run_done)
  );

  dlm_mode_fsm u_fsm (
    .clk(clk), .rst(rst), .hold_i(hold), .below_lo_i(vout_below_lo),
    .run_done_i(run_done), .mode_o(mode), .stay_burst_o(stay_burst)
  );

  dlm_burst_win u_win (
    .clk(clk), .rst(rst), .en_i(stay_burst),
    .below_nom_i(vout_below_nom), .above_hi_i(vout_above_hi),
    .hs_o(hs_burst_on)
  );

  assign burst_mode   = (mode == MODE_BURST);
  assign ilim_quarter = (mode == MODE_BURST);

  p_hs_needs_burst_r10: assert property (@(posedge clk) disable iff (rst)
    hs_burst_on |-> burst_mode);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!burst_mode && !hs_burst_on && !ilim_quarter));
endmodule

// File: tb/dual_mode_ctl_bench.sv
module dual_mode_ctl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 0, smp_heavy = 0, vout_below_nom = 0, vout_above_hi = 0;
  logic vout_below_lo = 0, force_pwm = 0, ss_active = 0;
  logic burst_mode, hs_burst_on, ilim_quarter;

  always #5 clk = ~clk;

  dual_mode_ctl u_dual_mode_ctl (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_heavy(smp_heavy),
    .vout_below_nom(vout_below_nom), .vout_above_hi(vout_above_hi),
    .vout_below_lo(vout_below_lo), .force_pwm(force_pwm), .ss_active(ss_active),
    .burst_mode(burst_mode), .hs_burst_on(hs_burst_on), .ilim_quarter(ilim_quarter)
  );

  typedef struct {
    logic  mode;
    logic  hs;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state, derived from the requirements.
  logic m_mode = 0, m_hs = 0;
  int   m_run  = 0;

  task automatic push_exp(input string tag);
    exp_t e;
    e.mode = m_mode; e.hs = m_hs; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_reset(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst = 1; smp_valid = 0; smp_heavy = 0; vout_below_nom = 0;
      vout_above_hi = 0; vout_below_lo = 0; force_pwm = 0; ss_active = 0;
      m_mode = 0; m_hs = 0; m_run = 0;
      push_exp("R1");
    end
    @(negedge clk);
    rst = 0;
  endtask

  task automatic step(input logic v, h, bn, ah, bl, f, s, input string tag);
    logic hold, nmode, nhs, stay;
    @(negedge clk);
    smp_valid = v; smp_heavy = h; vout_below_nom = bn; vout_above_hi = ah;
    vout_below_lo = bl; force_pwm = f; ss_active = s;
    hold  = f | s;
    stay  = m_mode && !hold && !bl;
    nhs   = stay ? (ah ? 1'b0 : (bn ? 1'b1 : m_hs)) : 1'b0;
    nmode = m_mode ? stay
                   : (!hold && v && !h && m_run >= 15);
    if (m_mode || hold) m_run = 0;
    else if (v) m_run = h ? 0 : (m_run < 16 ? m_run + 1 : m_run);
    m_mode = nmode; m_hs = nhs;
    push_exp(tag);
  endtask

  task automatic light(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: compare a little after each rising edge.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (burst_mode !== e.mode || hs_burst_on !== e.hs || ilim_quarter !== e.mode) begin
        errors++;
        $display("FAIL %s: mode/hs/ilim actual %b%b%b expected %b%b%b (R8 ilim follows mode)",
                 e.tag, burst_mode, hs_burst_on, ilim_quarter, e.mode, e.hs, e.mode);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(3);
    // R10: voltage flags in PWM do not touch the switch enable
    step(0, 0, 1, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 0, 1, 0, 0, "R10");
    // R2/R3: 15 light, one heavy restarts, 15 light stays PWM, 16th enters
    light(15, "R2");
    step(1, 1, 0, 0, 0, 0, 0, "R3");
    light(15, "R3");
    light(1, "R2");
    idle(2, "R8");
    // R7 window regulation
    step(0, 0, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, "R7");
    step(0, 0, 0, 1, 0, 0, 0, "R7");
    idle(2, "R7");
    step(0, 0, 1, 0, 0, 0, 0, "R7");
    // R11 both flags: off wins
    step(0, 0, 1, 1, 0, 0, 0, "R11");
    step(0, 0, 1, 0, 0, 0, 0, "R7");
    // R9 exit on low threshold with switch on
    step(0, 0, 1, 0, 1, 0, 0, "R9");
    idle(2, "R9");
    // R4 invalid heavy samples ignored within a run
    light(8, "R4");
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0, 0, "R4");
    light(7, "R4");
    light(1, "R4");
    idle(1, "R4");
    // R5 force in burst exits
    step(0, 0, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 1, 0, "R5");
    // R5 force clears the run
    light(10, "R5");
    step(1, 0, 0, 0, 0, 1, 0, "R5");
    light(15, "R5");
    light(1, "R5");
    // R6 soft-start in burst exits, and holds PWM through many light samples
    step(0, 0, 0, 0, 0, 0, 1, "R6");
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 0, 0, 1, "R6");
    light(15, "R6");
    light(1, "R6");
    // R1: reset from burst, then counter is fresh
    do_reset(1);
    light(15, "R1");
    light(1, "R1");
    idle(2, "R8");
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule